// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block converts one PWM command into separate enables for the high-side and low-side switches of a single buck-converter phase. It never lets both switches conduct at once. The dead time is not fixed. It stretches to follow two comparator bits. One reports that the low-side gate has discharged. The other reports that the switching node has fallen. A fixed extra delay is added before the high-side switch is allowed on.

Three timing rules sit on top of the basic sequence:
- Once the low-side switch has been released, it stays off for a minimum time.
- If the switching node never falls, for example under reverse inductor current, a timeout forces the low-side switch on anyway.
- A virtual phase-node totem pole follows the switch state. It is tri-stated whenever neither switch is on.

The PWM command and both comparator bits pass through two-flop synchronizers. Every delay is a whole number of clock cycles, derived from the clock-period parameter by rounding up. The supply-good and over-temperature status bits act without a synchronizer.

Top module: `gate_seq_top`

## Requirements
- R1: While `supply_ok_i` is 0, both enables are 0 and `vpn_o` is 2'b00 (tri-state) in that same cycle, whatever the other inputs do.
- R2: One cycle after `supply_ok_i` becomes 1, with over-temperature clear, the low-side enable is 1 and the high-side enable is 0.
- R3: While `over_temp_i` is 1, both enables are 0 in that same cycle. One cycle after it clears, the block restarts with only the low-side enable on.
- R4: When `pwm_i` rises, the low-side enable drops 3 cycles after the input changes (two synchronizer stages plus one state register).
- R5: The high-side enable rises only after the synchronized low-side comparator reads 1, followed by a further TG_CYC cycles. TG_CYC is 2 at the defaults (20 ns at a 10 ns clock). The enable is high 5 cycles after the comparator input rises.
- R6: When `pwm_i` falls, the high-side enable drops 3 cycles later. The low-side enable then stays 0 until the synchronized node comparator reads 1, and rises 3 cycles after that input rises.
- R7: If the node comparator stays 0 after a falling PWM sequence starts, the low-side enable is forced on FORCE_CYC cycles later. FORCE_CYC is 20 at the defaults (200 ns).
- R8: Once a rising PWM command releases the low-side enable, that enable stays 0 for at least MIN_CYC cycles, whatever PWM does. MIN_CYC is 8 at the defaults: 75 ns rounded up to whole cycles.
- R9: The two enables are never both 1 in the same cycle.
- R10: `vpn_o` encodes the totem-pole state as follows: 2'b10 drives high while the high-side enable is 1, 2'b01 drives low while the low-side enable is 1, and 2'b00 is tri-state otherwise.
- R11: A rising PWM command that arrives while the block waits for the node comparator aborts that wait. Both enables stay 0, later node-comparator activity cannot turn the low side on, and the high side follows the R5 rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM command, asynchronous |
| bg_low_i | input | 1 | Low-side gate below threshold, asynchronous |
| sw_low_i | input | 1 | Switching node below threshold, asynchronous |
| supply_ok_i | input | 1 | Supply good |
| over_temp_i | input | 1 | Over-temperature flag |
| tg_en_o | output | 1 | High-side gate enable |
| bg_en_o | output | 1 | Low-side gate enable |
| vpn_o | output | 2 | Virtual phase-node drive code |

## Verification
Each result has a fixed latency:
- A PWM or comparator change reaches the enables 3 cycles later.
- The high-side turn-on comes TG_CYC cycles after that.
- Supply and temperature changes act in the same cycle, and a restart shows one cycle later.

The directed checks drive inputs just after a falling clock edge. They sample one cycle before and in the cycle of each due change, so a result that comes early or late is caught. During random PWM and comparator traffic, the bench watches every cycle for overlap, for the drive code, for the low-side off-time length, and for the off time that precedes each high-side turn-on.

// File: rtl/gate_seq_pkg.sv
package gate_seq_pkg;

  typedef enum logic [2:0] {
    S_OFF,    // inhibited
    S_BOT,    // low side conducting
    S_BWAIT,  // low side released, waiting for its gate to discharge
    S_TDLY,   // fixed delay before high side
    S_TOP,    // high side conducting
    S_NWAIT   // high side released, waiting for node to fall
  } seq_state_e;

  localparam logic [1:0] VPN_TRI = 2'b00;
  localparam logic [1:0] VPN_LO  = 2'b01;
  localparam logic [1:0] VPN_HI  = 2'b10;

  function automatic int unsigned ceil_cycles(input int unsigned dur_ps,
                                              input int unsigned clk_ps);
    int unsigned c;
    c = (dur_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/gate_seq_sync.sv
module gate_seq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= 2'b00;
      else         stg_q <= {stg_q[0], d_i[i]};
    end
    assign q_o[i] = stg_q[1];
  end

endmodule

// File: rtl/gate_seq_fsm.sv
module gate_seq_fsm
  import gate_seq_pkg::*;
#(
  parameter int unsigned TG_CYC    = 2,
  parameter int unsigned FORCE_CYC = 20,
  parameter int unsigned MIN_CYC   = 8,
  parameter int unsigned DLY_W     = 5,
  parameter int unsigned MIN_W     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwm_i,
  input  logic       bg_low_i,
  input  logic       sw_low_i,
  input  logic       inhibit_i,
  output logic       tg_o,
  output logic       bg_o,
  output logic [1:0] vpn_o
);

  localparam logic [DLY_W-1:0] TG_LD    = DLY_W'(TG_CYC - 1);
  localparam logic [DLY_W-1:0] FORCE_LD = DLY_W'(FORCE_CYC - 1);
  localparam logic [MIN_W-1:0] MIN_LD   = MIN_W'(MIN_CYC - 1);

  seq_state_e       state_q, state_d;
  logic [DLY_W-1:0] dly_q;
  logic [MIN_W-1:0] min_q;
  logic             dly_done, min_done;

  assign dly_done = (dly_q == '0);
  assign min_done = (min_q == '0);

  always_comb begin
    state_d = state_q;
    if (inhibit_i) state_d = S_OFF;
    else begin
      unique case (state_q)
        S_OFF:   state_d = S_BOT;
        S_BOT:   if (pwm_i) state_d = S_BWAIT;
        S_BWAIT: begin
          if (!pwm_i)        state_d = S_NWAIT;
          else if (bg_low_i) state_d = S_TDLY;
        end
        S_TDLY: begin
          if (!pwm_i)        state_d = S_NWAIT;
          else if (dly_done) state_d = S_TOP;
        end
        S_TOP:   if (!pwm_i) state_d = S_NWAIT;
        S_NWAIT: begin
          if (pwm_i) state_d = S_BWAIT;  // abort, low side stays off
          else if ((sw_low_i || dly_done) && min_done) state_d = S_BOT;
        end
        default: state_d = S_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_OFF;
      dly_q   <= '0;
      min_q   <= '0;
    end else begin
      state_q <= state_d;
      // shared timer: top delay and node timeout never overlap
      if (state_d != state_q && state_d == S_TDLY)       dly_q <= TG_LD;
      else if (state_d != state_q && state_d == S_NWAIT) dly_q <= FORCE_LD;
      else if (!dly_done)                                dly_q <= dly_q - 1'b1;
      if (state_q == S_BOT && state_d == S_BWAIT) min_q <= MIN_LD;
      else if (!min_done)                         min_q <= min_q - 1'b1;
    end
  end

  assign tg_o  = (state_q == S_TOP) && !inhibit_i;
  assign bg_o  = (state_q == S_BOT) && !inhibit_i;
  assign vpn_o = tg_o ? VPN_HI : (bg_o ? VPN_LO : VPN_TRI);

  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tg_o && bg_o));

  a_r3_inhibit_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inhibit_i |=> (!tg_o && !bg_o));

  a_r5_top_after_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tg_o) |-> ($past(state_q) == S_TDLY && $past(dly_done)));

  a_r8_min_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bg_o) && $past(state_q) == S_NWAIT) |-> $past(min_done));

  a_r6_node_or_timeout: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(bg_o) && $past(state_q) == S_NWAIT) |-> ($past(sw_low_i) || $past(dly_done)));

endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
  import gate_seq_pkg::*;
#(
  parameter int unsigned CLK_PS      = 10000,
  parameter int unsigned TG_DLY_PS   = 20000,
  parameter int unsigned MIN_OFF_PS  = 75000,
  parameter int unsigned FORCE_BG_PS = 200000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwm_i,
  input  logic       bg_low_i,
  input  logic       sw_low_i,
  input  logic       supply_ok_i,
  input  logic       over_temp_i,
  output logic       tg_en_o,
  output logic       bg_en_o,
  output logic [1:0] vpn_o
);

  localparam int unsigned TG_CYC    = ceil_cycles(TG_DLY_PS, CLK_PS);
  localparam int unsigned MIN_CYC   = ceil_cycles(MIN_OFF_PS, CLK_PS);
  localparam int unsigned FORCE_CYC = ceil_cycles(FORCE_BG_PS, CLK_PS);
  localparam int unsigned DLY_MAX   = (TG_CYC > FORCE_CYC) ? TG_CYC : FORCE_CYC;
  localparam int unsigned DLY_W     = $clog2(DLY_MAX + 1);
  localparam int unsigned MIN_W     = $clog2(MIN_CYC + 1);

  logic [2:0] raw_in, syn_in;
  logic       inhibit;

  assign raw_in  = {pwm_i, bg_low_i, sw_low_i};
  assign inhibit = !supply_ok_i || over_temp_i;

  gate_seq_sync #(.W(3)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (syn_in)
  );

  gate_seq_fsm #(
    .TG_CYC    (TG_CYC),
    .FORCE_CYC (FORCE_CYC),
    .MIN_CYC   (MIN_CYC),
    .DLY_W     (DLY_W),
    .MIN_W     (MIN_W)
  ) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwm_i     (syn_in[2]),
    .bg_low_i  (syn_in[1]),
    .sw_low_i  (syn_in[0]),
    .inhibit_i (inhibit),
    .tg_o      (tg_en_o),
    .bg_o      (bg_en_o),
    .vpn_o     (vpn_o)
  );

endmodule

// File: tb/tb_gate_seq_top.sv
module tb_gate_seq_top;

  localparam int unsigned TG_CYC    = (20000 + 9999) / 10000;
  localparam int unsigned MIN_CYC   = (75000 + 9999) / 10000;
  localparam int unsigned FORCE_CYC = (200000 + 9999) / 10000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       pwm = 1'b0, bg_low = 1'b0, sw_low = 1'b0;
  logic       sup_ok = 1'b0, otemp = 1'b0;
  logic       tg, bg;
  logic [1:0] vpn;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gate_seq_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .pwm_i(pwm), .bg_low_i(bg_low),
    .sw_low_i(sw_low), .supply_ok_i(sup_ok), .over_temp_i(otemp),
    .tg_en_o(tg), .bg_en_o(bg), .vpn_o(vpn)
  );

  function automatic logic [1:0] exp_vpn(input logic t, input logic b);
    return t ? 2'b10 : (b ? 2'b01 : 2'b00);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_gates(input string req, input logic et, input logic eb);
    chk(tg == et, {req, " tg"}, int'(tg), int'(et));
    chk(bg == eb, {req, " bg"}, int'(bg), int'(eb));
    chk(vpn == exp_vpn(et, eb), {req, " vpn"}, int'(vpn), int'(exp_vpn(et, eb)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    tick(2);
    chk_gates("reset", 1'b0, 1'b0);
    rst_ni = 1'b1;
    // R1: supply not ok, PWM toggling ignored
    pwm = 1'b1; tick(5);
    chk_gates("R1", 1'b0, 1'b0);
    pwm = 1'b0; tick(4);
    // R2
    sup_ok = 1'b1; tick(1);
    chk_gates("R2", 1'b0, 1'b1);
    // R4 / R5
    pwm = 1'b1; tick(2);
    chk_gates("R4 early", 1'b0, 1'b1);
    tick(1);
    chk_gates("R4", 1'b0, 1'b0);
    tick(10);
    chk_gates("R5 wait bg_low", 1'b0, 1'b0);
    bg_low = 1'b1; tick(4);
    chk_gates("R5 early", 1'b0, 1'b0);
    tick(1);
    chk_gates("R5 R10", 1'b1, 1'b0);
    // R6
    bg_low = 1'b0; pwm = 1'b0; tick(2);
    chk_gates("R6 early", 1'b1, 1'b0);
    tick(1);
    chk_gates("R6 R10 tri", 1'b0, 1'b0);
    tick(5);
    chk_gates("R6 wait node", 1'b0, 1'b0);
    sw_low = 1'b1; tick(2);
    chk_gates("R6 node early", 1'b0, 1'b0);
    tick(1);
    chk_gates("R6 node", 1'b0, 1'b1);
    // R7 forced low side
    sw_low = 1'b0; pwm = 1'b1; tick(3);
    bg_low = 1'b1; tick(5);
    chk_gates("R7 top on", 1'b1, 1'b0);
    pwm = 1'b0; tick(3);
    chk_gates("R7 released", 1'b0, 1'b0);
    tick(FORCE_CYC - 1);
    chk_gates("R7 before timeout", 1'b0, 1'b0);
    tick(1);
    chk_gates("R7 forced", 1'b0, 1'b1);
    // R8 narrow pulse
    sw_low = 1'b1; tick(3);
    pwm = 1'b1; tick(1);
    pwm = 1'b0; tick(2);
    chk_gates("R8 off", 1'b0, 1'b0);
    tick(MIN_CYC - 1);
    chk_gates("R8 still off", 1'b0, 1'b0);
    tick(1);
    chk_gates("R8 back on", 1'b0, 1'b1);
    // R11 abort
    bg_low = 1'b0; sw_low = 1'b0; tick(3);
    pwm = 1'b1; tick(3);
    bg_low = 1'b1; tick(5);
    chk_gates("R11 top", 1'b1, 1'b0);
    pwm = 1'b0; bg_low = 1'b0; tick(3);
    chk_gates("R11 released", 1'b0, 1'b0);
    tick(3);
    pwm = 1'b1; tick(2);
    sw_low = 1'b1; tick(10);
    chk_gates("R11 aborted", 1'b0, 1'b0);
    bg_low = 1'b1; tick(4);
    chk_gates("R11 wait", 1'b0, 1'b0);
    tick(1);
    chk_gates("R11 top again", 1'b1, 1'b0);
    // R3 over-temperature
    otemp = 1'b1; #1;
    chk_gates("R3 immediate", 1'b0, 1'b0);
    tick(3);
    chk_gates("R3 held", 1'b0, 1'b0);
    otemp = 1'b0; tick(1);
    chk_gates("R3 restart", 1'b0, 1'b1);
    tick(6);
    // R1 supply drop mid-run
    sup_ok = 1'b0; #1;
    chk_gates("R1 drop", 1'b0, 1'b0);
    tick(3);
    chk_gates("R1 held", 1'b0, 1'b0);
    pwm = 1'b0; bg_low = 1'b0; sw_low = 1'b0;
    sup_ok = 1'b1; tick(1);
    chk_gates("R2 again", 1'b0, 1'b1);

    // random traffic with per-cycle invariants
    begin
      int  hold = 0;
      int  off_run = 0;
      bit  run_valid = 1'b0;
      logic prev_tg = tg, prev_bg = bg;
      for (int c = 0; c < 6000; c++) begin
        if (hold == 0) begin
          pwm  = ~pwm;
          hold = 2 + int'($urandom_range(0, 30));
        end else hold--;
        if ($urandom_range(0, 7) == 0) bg_low = ~bg_low;
        if ($urandom_range(0, 9) == 0) sw_low = ~sw_low;
        tick(1);
        chk(!(tg && bg), "R9 overlap", int'({tg, bg}), 0);
        chk(vpn == exp_vpn(tg, bg), "R10 code", int'(vpn), int'(exp_vpn(tg, bg)));
        if (prev_bg && !bg) begin
          off_run = 1; run_valid = 1'b1;
        end else if (!bg) off_run++;
        if (!prev_bg && bg && run_valid)
          chk(off_run >= int'(MIN_CYC), "R8 off run", off_run, int'(MIN_CYC));
        if (!prev_tg && tg && run_valid)
          chk(off_run >= int'(TG_CYC) + 1, "R5 gap", off_run, int'(TG_CYC) + 1);
        prev_tg = tg; prev_bg = bg;
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule